// File: doc/BRIEF.md
# VLIW bundle slot dispatcher

The dispatcher sits between an instruction fetch stage and a set of typed execution-unit ports. Each cycle it may take one 128-bit bundle holding three 41-bit instruction slots and a 5-bit template code. The compiler has already chosen that code. The dispatcher does not work out at run time which instructions can run in parallel. It looks the template up in a fixed table, which gives a unit class for each slot. There are four classes: integer/logic, memory load/store, floating point and branch. Each slot then goes to the output port of its class.

There are five output ports: two integer ports, one memory port, one floating-point port and one branch port. Each port has its own valid/ready pair and a registered payload. The payload is the 41-bit instruction plus the index of the slot it came from. A bundle goes out as a whole. It is taken only when every port it needs can accept in that cycle. Otherwise it waits at the input, and no port receives any part of it. A template code that is not in the table marks a malformed bundle. Such a bundle is taken at once and thrown away, and a one-cycle error flag reports it.

Top module: `vliw_dispatch`

## Requirements
- R1: The bundle layout is fixed: slot 1 at bits [127:87], slot 2 at [86:46], slot 3 at [45:5] and the template at [4:0]. Each output carries the instruction unchanged, together with the slot index of its source: 0 for slot 1, 1 for slot 2, 2 for slot 3.
- R2: Port index p selects out_valid[p], out_ready[p], out_insn[41p+40:41p] and out_slot[2p+1:2p]. The ports are 0 = integer A, 1 = integer B, 2 = memory, 3 = float, 4 = branch. The legal templates give the unit class of slots 1/2/3 as follows: 0x00 M,I,I; 0x01 M,I,B; 0x02 M,F,I; 0x03 M,I,F; 0x04 I,I,B; 0x05 I,F,B; 0x06 I,I,F; 0x08 I,M,F; 0x1D M,F,B. When a bundle has two integer slots, the lower-numbered one goes to port 0 and the other to port 1. A single integer slot always goes to port 0.
- R3: A legal bundle is taken only in a cycle when every port it targets can accept. A port can accept when its output is empty or its ready is high. In any other cycle in_ready is low, the bundle is held and no port loads any of its slots.
- R4: While out_valid[p] is high and out_ready[p] is low, the port keeps valid high and its payload unchanged.
- R5: A bundle whose template is not listed in R2 is taken at once, whatever the port readiness (in_ready high). No port loads from it, and err_tmpl is high for exactly the one cycle after it is taken. Each such bundle gives one cycle of err_tmpl.
- R6: The slots of a bundle taken at a clock edge appear on their ports from that edge onward, in the next cycle. Ports that the bundle does not target get nothing from it.
- R7: The reset is synchronous and active high. It clears every out_valid and err_tmpl, even when outputs are pending.
- R8: When all ports are ready, a bundle is taken every cycle with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered by fetch |
| in_ready | output | 1 | Bundle taken this cycle when in_valid is high |
| in_bundle | input | 128 | Three slots plus template |
| out_valid | output | 5 | Per-port instruction valid |
| out_ready | input | 5 | Per-port unit ready |
| out_insn | output | 205 | Per-port 41-bit instruction, packed by port index |
| out_slot | output | 10 | Per-port 2-bit source slot index |
| err_tmpl | output | 1 | One-cycle flag for a dropped reserved-template bundle |

## Verification
The assertions assume that the fetch side keeps in_bundle stable while in_valid is high and in_ready is low. They also assume that nothing is read on the bundle while in_valid is low, so the template decode is checked only for offered bundles. The bench changes the bundle only after it has seen the bundle taken. It drives the unit ready lines a fixed delay after each edge, so they are stable across the next edge. Randomised readiness and a mix of legal and reserved templates exercise the stall path. Directed sequences hold individual ports full to test the all-or-nothing rule.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  localparam int NSLOT  = 3;
  localparam int NPORT  = 5;
  localparam int SIDX_W = 2;

  typedef enum logic [1:0] {K_I = 2'd0, K_M = 2'd1, K_F = 2'd2, K_B = 2'd3} kind_e;

  localparam int P_IA = 0;
  localparam int P_IB = 1;
  localparam int P_M  = 2;
  localparam int P_F  = 3;
  localparam int P_B  = 4;
endpackage

// File: rtl/vd_tmpl_decode.sv
module vd_tmpl_decode
  import vdisp_pkg::*;
#(
  parameter int TMPL_W = 5
) (
  input  logic [TMPL_W-1:0]  tmpl,
  output logic               legal,
  output kind_e [NSLOT-1:0]  kinds
);
  always_comb begin
    legal    = 1'b1;
    kinds[0] = K_I;
    kinds[1] = K_I;
    kinds[2] = K_I;
    case (int'(tmpl))
      0:  begin kinds[0] = K_M; kinds[1] = K_I; kinds[2] = K_I; end
      1:  begin kinds[0] = K_M; kinds[1] = K_I; kinds[2] = K_B; end
      2:  begin kinds[0] = K_M; kinds[1] = K_F; kinds[2] = K_I; end
      3:  begin kinds[0] = K_M; kinds[1] = K_I; kinds[2] = K_F; end
      4:  begin kinds[0] = K_I; kinds[1] = K_I; kinds[2] = K_B; end
      5:  begin kinds[0] = K_I; kinds[1] = K_F; kinds[2] = K_B; end
      6:  begin kinds[0] = K_I; kinds[1] = K_I; kinds[2] = K_F; end
      8:  begin kinds[0] = K_I; kinds[1] = K_M; kinds[2] = K_F; end
      29: begin kinds[0] = K_M; kinds[1] = K_F; kinds[2] = K_B; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vd_slot_router.sv
module vd_slot_router
  import vdisp_pkg::*;
(
  input  logic                          legal,
  input  kind_e [NSLOT-1:0]             kinds,
  output logic  [NPORT-1:0]             tgt,
  output logic  [NPORT-1:0][SIDX_W-1:0] sel
);
  logic int_used;

  always_comb begin
    tgt      = '0;
    sel      = '0;
    int_used = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      case (kinds[s])
        K_I: begin
          if (!int_used) begin
            tgt[P_IA] = 1'b1;
            sel[P_IA] = SIDX_W'(s);
            int_used  = 1'b1;
          end else begin
            tgt[P_IB] = 1'b1;
            sel[P_IB] = SIDX_W'(s);
          end
        end
        K_M: begin tgt[P_M] = 1'b1; sel[P_M] = SIDX_W'(s); end
        K_F: begin tgt[P_F] = 1'b1; sel[P_F] = SIDX_W'(s); end
        default: begin tgt[P_B] = 1'b1; sel[P_B] = SIDX_W'(s); end
      endcase
    end
    if (!legal) tgt = '0;
  end
endmodule

// File: rtl/vd_port_reg.sv
module vd_port_reg #(
  parameter int DW = 43
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] q,
  output logic          can_take
);
  assign can_take = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  // R4: a stalled output keeps its valid and payload
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(q));
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vdisp_pkg::*;
#(
  parameter int SLOT_W = 41,
  parameter int TMPL_W = 5,
  localparam int BUNDLE_W = NSLOT * SLOT_W + TMPL_W,
  localparam int DW = SIDX_W + SLOT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BUNDLE_W-1:0]       in_bundle,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT*SLOT_W-1:0]   out_insn,
  output logic [NPORT*SIDX_W-1:0]   out_slot,
  output logic                      err_tmpl
);
  logic [SLOT_W-1:0]             slot_w [NSLOT];
  logic                          legal;
  kind_e [NSLOT-1:0]             kinds;
  logic [NPORT-1:0]              tgt;
  logic [NPORT-1:0][SIDX_W-1:0]  sel;
  logic [NPORT-1:0]              can_take;
  logic                          fire;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_w[s] = in_bundle[BUNDLE_W-1-s*SLOT_W -: SLOT_W];
  end

  vd_tmpl_decode #(.TMPL_W(TMPL_W)) u_dec (
    .tmpl  (in_bundle[TMPL_W-1:0]),
    .legal (legal),
    .kinds (kinds)
  );

  vd_slot_router u_route (
    .legal (legal),
    .kinds (kinds),
    .tgt   (tgt),
    .sel   (sel)
  );

  assign in_ready = !legal || ((can_take | ~tgt) == {NPORT{1'b1}});
  assign fire     = in_valid && in_ready;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DW-1:0] q;
    vd_port_reg #(.DW(DW)) u_preg (
      .clk      (clk),
      .rst      (rst),
      .load     (fire && tgt[p]),
      .d        ({sel[p], slot_w[sel[p]]}),
      .ready    (out_ready[p]),
      .valid    (out_valid[p]),
      .q        (q),
      .can_take (can_take[p])
    );
    assign out_insn[p*SLOT_W +: SLOT_W] = q[SLOT_W-1:0];
    assign out_slot[p*SIDX_W +: SIDX_W] = q[DW-1:SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) err_tmpl <= 1'b0;
    else     err_tmpl <= in_valid && !legal;
  end

  // R2: every offered legal bundle maps its three slots onto three distinct ports
  a_r2_three_targets: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal |-> $countones(tgt) == NSLOT);

  // R3: a taken legal bundle leaves every targeted port holding an item
  a_r3_whole_issue: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && legal |=> (out_valid & $past(tgt)) == $past(tgt));

  // R5: a reserved bundle loads no port
  a_r5_drop_no_load: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legal |=> out_valid == ($past(out_valid) & ~$past(out_ready)));

  // R7: reset leaves outputs idle
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_valid == '0 && !err_tmpl);
endmodule

// File: tb/vliw_dispatch_tb_top.sv
`timescale 1ns/1ps
module vliw_dispatch_tb_top;
  localparam int SW = 41;
  localparam int NP = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [127:0]   in_bundle = '0;
  logic [NP-1:0]  out_valid;
  logic [NP-1:0]  out_ready = '0;
  logic [NP*SW-1:0] out_insn;
  logic [NP*2-1:0]  out_slot;
  logic           err_tmpl;

  int n_cmp = 0;
  int n_bad = 0;
  int err_exp = 0;
  int err_seen = 0;
  int rdy_mode = 0;   // 0 all ready, 1 random, 2 manual
  int waits = 0;
  bit done = 0;

  logic [SW+1:0] exp_q [NP][$];

  always #10 clk = ~clk;

  vliw_dispatch dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_slot(out_slot), .err_tmpl(err_tmpl)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // class per slot: 0 I, 1 M, 2 F, 3 B ; returns legal
  function automatic bit ref_kinds(input int t, output int k0, output int k1, output int k2);
    ref_kinds = 1;
    k0 = 0; k1 = 0; k2 = 0;
    case (t)
      0:  begin k0 = 1; k1 = 0; k2 = 0; end
      1:  begin k0 = 1; k1 = 0; k2 = 3; end
      2:  begin k0 = 1; k1 = 2; k2 = 0; end
      3:  begin k0 = 1; k1 = 0; k2 = 2; end
      4:  begin k0 = 0; k1 = 0; k2 = 3; end
      5:  begin k0 = 0; k1 = 2; k2 = 3; end
      6:  begin k0 = 0; k1 = 0; k2 = 2; end
      8:  begin k0 = 0; k1 = 1; k2 = 2; end
      29: begin k0 = 1; k1 = 2; k2 = 3; end
      default: ref_kinds = 0;
    endcase
  endfunction

  function automatic logic [127:0] mk(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                      input logic [SW-1:0] c, input logic [4:0] t);
    mk = {a, b, c, t};
  endfunction

  function automatic logic [SW-1:0] rnd41();
    rnd41 = {$urandom(), $urandom()};
  endfunction

  task automatic push_exp(input logic [127:0] b);
    int k [3];
    bit lg;
    bit iused;
    int port;
    lg = ref_kinds(int'(b[4:0]), k[0], k[1], k[2]);
    if (!lg) begin
      err_exp++;
      return;
    end
    iused = 0;
    for (int s = 0; s < 3; s++) begin
      case (k[s])
        0: begin port = iused ? 1 : 0; iused = 1; end
        1: port = 2;
        2: port = 3;
        default: port = 4;
      endcase
      exp_q[port].push_back({2'(s), b[127 - s*SW -: SW]});
    end
  endtask

  task automatic send(input logic [127:0] b);
    @(posedge clk); #1;
    in_valid  = 1'b1;
    in_bundle = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
      @(posedge clk); #1;
    end
    push_exp(b);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  function automatic bit queues_empty();
    queues_empty = 1;
    for (int p = 0; p < NP; p++) if (exp_q[p].size() != 0) queues_empty = 0;
  endfunction

  // ready driver
  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = '1;
    else if (rdy_mode == 1) out_ready = NP'($urandom());
  end

  // monitor / scoreboard (R1, R2, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (err_tmpl) err_seen++;
      for (int p = 0; p < NP; p++) begin
        if (out_valid[p] && out_ready[p]) begin
          logic [SW+1:0] got;
          got = {out_slot[p*2 +: 2], out_insn[p*SW +: SW]};
          if (exp_q[p].size() == 0) begin
            chk(0, "R6 unexpected item", 64'(got), 64'(p));
          end else begin
            logic [SW+1:0] e;
            e = exp_q[p].pop_front();
            chk(got == e, "R1 R2 port payload", 64'(got), 64'(e));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int legal_t [9] = '{0, 1, 2, 3, 4, 5, 6, 8, 29};
    logic [127:0] bx, by;
    logic [SW-1:0] x3;

    // reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R7 reset valids", 64'(out_valid), 0);
    chk(err_tmpl == 1'b0, "R7 reset err", 64'(err_tmpl), 0);

    // R8 all ready, back to back, every legal template twice
    rdy_mode = 0;
    waits = 0;
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 9; i++)
        send(mk(rnd41(), rnd41(), rnd41(), 5'(legal_t[i])));
    chk(waits == 0, "R8 no stalls when all ready", 64'(waits), 0);
    idle(4);

    // random readiness with reserved templates mixed in (R2, R3, R5)
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [4:0] t;
      if ($urandom_range(0, 4) == 0) t = 5'($urandom());
      else t = 5'(legal_t[$urandom_range(0, 8)]);
      send(mk(rnd41(), rnd41(), rnd41(), t));
    end
    idle(2);
    rdy_mode = 0;
    repeat (6) @(posedge clk);
    chk(queues_empty(), "R3 random phase drained", 0, 0);

    // directed stall: all-or-nothing (R3) and hold (R4)
    rdy_mode = 2;
    @(posedge clk); #1;
    out_ready = '0;
    x3 = rnd41();
    bx = mk(rnd41(), rnd41(), x3, 5'd29);
    by = mk(rnd41(), rnd41(), rnd41(), 5'd29);
    in_valid = 1'b1; in_bundle = bx;
    @(negedge clk);
    chk(in_ready == 1'b1, "R3 empty ports accept", 64'(in_ready), 1);
    push_exp(bx);
    @(posedge clk); #1;
    in_bundle = by;
    @(negedge clk);
    chk(in_ready == 1'b0, "R3 full ports stall", 64'(in_ready), 0);
    chk(out_valid == 5'b11100, "R6 targeted ports only", 64'(out_valid), 64'h1c);
    @(posedge clk); #1;
    out_ready = 5'b01100;
    @(negedge clk);
    chk(in_ready == 1'b0, "R3 branch port still full", 64'(in_ready), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 5'b10000, "R3 no partial issue", 64'(out_valid), 64'h10);
    chk(in_ready == 1'b0, "R3 held while one port full", 64'(in_ready), 0);
    chk(out_insn[4*SW +: SW] == x3, "R4 stalled payload held", 64'(out_insn[4*SW +: SW]), 64'(x3));
    @(posedge clk); #1;
    out_ready = 5'b11100;
    @(negedge clk);
    chk(in_ready == 1'b1, "R3 accept when draining", 64'(in_ready), 1);
    push_exp(by);
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = '0;
    @(negedge clk);
    chk(out_valid == 5'b11100, "R6 second bundle loaded", 64'(out_valid), 64'h1c);

    // reserved template while ports full (R5)
    @(posedge clk); #1;
    in_valid = 1'b1; in_bundle = mk(rnd41(), rnd41(), rnd41(), 5'd31);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 reserved taken despite full ports", 64'(in_ready), 1);
    push_exp(in_bundle);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(err_tmpl == 1'b1, "R5 error pulse", 64'(err_tmpl), 1);
    chk(out_valid == 5'b11100, "R5 no port loaded", 64'(out_valid), 64'h1c);
    @(negedge clk);
    chk(err_tmpl == 1'b0, "R5 pulse one cycle", 64'(err_tmpl), 0);

    // reset with pending outputs (R7)
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R7 reset clears pending", 64'(out_valid), 0);
    for (int p = 0; p < NP; p++) exp_q[p].delete();

    // after reset, traffic resumes (R1)
    rdy_mode = 0;
    send(mk(rnd41(), rnd41(), rnd41(), 5'd0));
    send(mk(rnd41(), rnd41(), rnd41(), 5'd6));
    idle(4);
    chk(queues_empty(), "R1 final drain", 0, 0);
    chk(err_seen == err_exp, "R5 error count", 64'(err_seen), 64'(err_exp));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule